// File: doc/BRIEF.md
# Fine-Step Delta-Sigma Ratio Modulator

This block turns a static fractional division ratio into a stream of instantaneous ratios, one per reference event, for a fractional-N synthesiser whose divider is built from eight parallel slices. Each output is an integer modulus base together with a 3-bit count of eighths. The count says how many of the eight slices divide by base+1 in that event, while the rest divide by base. The instantaneous ratio is therefore base + k/8. Because the quantisation step is one eighth, the noise the loop has to filter is far smaller than with a modulator that only emits whole-integer steps.

The programmed ratio has an 8-bit integer part and a 16-bit fraction. The top three bits of the fraction count whole eighths and go straight into the output sum. The remaining thirteen bits are the part below one eighth. A third-order cascade of three first-order accumulators shapes that part, and each accumulator carries at the one-eighth weight. The cascade's correction, counted in eighths, is added to the coarse eighths. That sum can fall below zero or reach eight or more, so it is split with a floor into an integer adjustment of the base and a remainder in 0..7. The state advances only on cycles where the enable input is high, which marks one reference event.

Top module: `fine_ratio_dsm`

## Requirements
- R1: A synchronous reset drives both outputs to zero and clears all modulator state. After that, the first enabled event yields exactly base = ratio_int and k = ratio_frac[15:13].
- R2: While en is low, the outputs hold their values and the state stays frozen. After resuming, the output sequence matches, event for event, the sequence of an uninterrupted run from reset.
- R3: On every enabled event, the relative code rel = 8*base + k − (8*ratio_int + ratio_frac[15:13]) lies in −3..+4.
- R4: Over T enabled events after reset with a constant input, the sum of rel equals floor(T*ratio_frac[12:0]/8192) to within −1..+2. The long-run average therefore equals the programmed ratio.
- R5: When ratio_frac[12:0] is zero, every enabled event yields exactly base = ratio_int and k = ratio_frac[15:13].
- R6: For a ratio near 10.6, at least 40% of the events give 10.5 or 10.625, which are the two neighbouring eighths. Both of these values occur.
- R7: A negative sum borrows from the integer part, so base = ratio_int − 1 and k = 8 + sum. A sum of eight or more carries into it, so base = ratio_int + 1. With ratio_int ≥ 4, base never drops below 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance one reference event |
| ratio_int | input | 8 | Integer part of the ratio, at least 4 |
| ratio_frac | input | 16 | Fractional part of the ratio, in units of 1/65536 |
| mod_base | output | 8 | Integer modulus base for this event |
| eighths | output | 3 | Number of slices that use base+1 in this event |

## Verification
A corrupted accumulator or a carry with the wrong delay does not break the per-event range at once. It shows up as a drift of the running sum of rel away from floor(T*fraction), and that drift crosses the −1..+2 window within a few dozen events. Wrong borrow handling shows up on the first negative correction, either as a base above ratio_int with a large eighths count or as a rel outside −3..+4. A leak through a low enable appears as a changed output during the idle cycle, or as a sequence that splits off from the gap-free run at the first event after the gap.

// File: rtl/fine_ratio_dsm.sv
module fine_ratio_dsm #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  ratio_int,
  input  logic [FRAC_W-1:0] ratio_frac,
  output logic [INT_W-1:0]  mod_base,
  output logic [STEP_W-1:0] eighths
);
  localparam int LW = FRAC_W - STEP_W;
  localparam int QW = STEP_W + 3;

  logic [LW-1:0] acc1, acc2, acc3;
  logic          c2_d, c3_d, c3_dd;

  wire [LW-1:0] fine   = ratio_frac[LW-1:0];
  wire [LW:0]   sum1   = {1'b0, acc1} + {1'b0, fine};
  wire [LW:0]   sum2   = {1'b0, acc2} + {1'b0, sum1[LW-1:0]};
  wire [LW:0]   sum3   = {1'b0, acc3} + {1'b0, sum2[LW-1:0]};
  wire          c1     = sum1[LW];
  wire          c2     = sum2[LW];
  wire          c3     = sum3[LW];

  logic signed [QW-1:0]    corr, q;
  logic signed [INT_W-1:0] adj;

  assign corr = QW'(c1) + QW'(c2) - QW'(c2_d) + QW'(c3) - (QW'(c3_d) << 1) + QW'(c3_dd);
  assign q    = QW'(ratio_frac[FRAC_W-1 -: STEP_W]) + corr;
  assign adj  = INT_W'(q >>> STEP_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc1     <= '0;
      acc2     <= '0;
      acc3     <= '0;
      c2_d     <= 1'b0;
      c3_d     <= 1'b0;
      c3_dd    <= 1'b0;
      mod_base <= '0;
      eighths  <= '0;
    end else if (en) begin
      acc1     <= sum1[LW-1:0];
      acc2     <= sum2[LW-1:0];
      acc3     <= sum3[LW-1:0];
      c2_d     <= c2;
      c3_d     <= c3;
      c3_dd    <= c3_d;
      mod_base <= ratio_int + adj;
      eighths  <= q[STEP_W-1:0];
    end
  end
endmodule

module fine_ratio_dsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [7:0] ratio_int,
  input logic [15:0] ratio_frac,
  input logic [7:0] mod_base,
  input logic [2:0] eighths
);
  int   ref_code;
  logic fresh;
  int   out_code;

  assign out_code = 8 * int'(mod_base) + int'(eighths);

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh    <= 1'b1;
      ref_code <= 0;
    end else if (en) begin
      fresh    <= 1'b0;
      ref_code <= 8 * int'(ratio_int) + int'(ratio_frac[15:13]);
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (mod_base == 8'd0 && eighths == 3'd0));

  a_r1_first_event: assert property (@(posedge clk) disable iff (rst)
    (fresh && en) |=> (mod_base == $past(ratio_int) && eighths == $past(ratio_frac[15:13])));

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(mod_base) && $stable(eighths)));

  a_r3_code_window: assert property (@(posedge clk) disable iff (rst)
    en |=> (out_code >= ref_code - 3 && out_code <= ref_code + 4));
endmodule

bind fine_ratio_dsm fine_ratio_dsm_chk i_chk (
  .clk(clk), .rst(rst), .en(en), .ratio_int(ratio_int), .ratio_frac(ratio_frac),
  .mod_base(mod_base), .eighths(eighths)
);

// File: tb/test_fine_ratio_dsm.sv
module test_fine_ratio_dsm;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [7:0] n_in = 8'd4;
  logic [15:0] f_in = 16'd0;
  logic [7:0] base;
  logic [2:0] k;

  always #10 clk = ~clk;

  fine_ratio_dsm i_fine_ratio_dsm (
    .clk(clk), .rst(rst), .en(en), .ratio_int(n_in), .ratio_frac(f_in),
    .mod_base(base), .eighths(k)
  );

  int checks = 0;
  int fails  = 0;

  longint run_sum;
  int     hist [8];
  int     out_of_range;
  int     seen_lo, seen_hi, min_base;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint rel_of(input logic [7:0] b, input logic [2:0] kk,
                                    input logic [7:0] n, input logic [15:0] f);
    return 8 * longint'(b) + longint'(kk) - 8 * longint'(n) - longint'(f[15:13]);
  endfunction

  function automatic longint floor_sum(input int t, input logic [15:0] f);
    return (longint'(t) * longint'(f[12:0])) >>> 13;
  endfunction

  task automatic tick(input bit e);
    en = e;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1'b0);
    tick(1'b0);
    rst = 1'b0;
  endtask

  task automatic run_cfg(input logic [7:0] n, input logic [15:0] f, input int t, input bit gaps);
    int done;
    longint r;
    do_reset();
    n_in = n; f_in = f;
    run_sum = 0; out_of_range = 0; seen_lo = 0; seen_hi = 0; min_base = 255;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    done = 0;
    while (done < t) begin
      bit e;
      e = gaps ? (($urandom % 4) != 0) : 1'b1;
      tick(e);
      if (e) begin
        done++;
        r = rel_of(base, k, n, f);
        run_sum += r;
        if (r < -3 || r > 4) out_of_range++;
        else hist[int'(r) + 3]++;
        if (int'(base) == int'(n) - 1) seen_lo++;
        if (int'(base) == int'(n) + 1) seen_hi++;
        if (int'(base) < min_base) min_base = int'(base);
      end
    end
    en = 1'b0;
  endtask

  task automatic check_stats(input logic [15:0] f, input int t, input string tag);
    longint d;
    check(out_of_range == 0, "R3", {tag, " rel outside -3..4 count"}, out_of_range, 0);
    d = run_sum - floor_sum(t, f);
    check(d >= -1 && d <= 2, "R4", {tag, " running sum minus floor"}, run_sum, floor_sum(t, f));
  endtask

  logic [7:0] seq_b [40];
  logic [2:0] seq_k [40];

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    check(base == 8'd0 && k == 3'd0, "R1", "outputs after reset", {base, k}, 0);
    tick(1'b0);
    check(base == 8'd0 && k == 3'd0, "R2", "reset value held while idle", {base, k}, 0);

    // R1: first event after reset is exact
    n_in = 8'd12; f_in = 16'hA5C3;
    tick(1'b1);
    check(base == 8'd12, "R1", "first event base", base, 12);
    check(k == 3'd5, "R1", "first event eighths", k, 5);

    // R5: no fine bits gives a constant output
    begin
      int bad;
      do_reset();
      n_in = 8'd7; f_in = 16'h6000;
      bad = 0;
      for (int i = 0; i < 60; i++) begin
        tick(1'b1);
        if (base != 8'd7 || k != 3'd3) bad++;
      end
      check(bad == 0, "R5", "events differing from 7+3/8", bad, 0);
    end

    // R6 / R3 / R4: ratio near 10.6
    run_cfg(8'd10, 16'd39322, 4000, 1'b0);
    check_stats(16'd39322, 4000, "ratio 10.6");
    check((hist[3] + hist[4]) * 10 >= 4000 * 4, "R6", "events at 10.5 or 10.625", hist[3] + hist[4], 1600);
    check(hist[3] > 0 && hist[4] > 0, "R6", "both neighbours seen", hist[3] * 10000 + hist[4], 1);

    // R4 with idle gaps: ratio 10.57
    run_cfg(8'd10, 16'd37355, 4000, 1'b1);
    check_stats(16'd37355, 4000, "ratio 10.57 gapped");

    // R7: borrow below the integer part
    run_cfg(8'd20, 16'd4000, 2000, 1'b0);
    check_stats(16'd4000, 2000, "borrow case");
    check(seen_lo > 0, "R7", "base below ratio_int seen", seen_lo, 1);

    // R7: carry above the integer part
    run_cfg(8'd30, 16'hFF00, 2000, 1'b0);
    check_stats(16'hFF00, 2000, "carry case");
    check(seen_hi > 0, "R7", "base above ratio_int seen", seen_hi, 1);

    // R7: minimum integer part keeps base at 3 or more
    run_cfg(8'd4, 16'd1500, 2000, 1'b1);
    check_stats(16'd1500, 2000, "minimum integer");
    check(min_base >= 3, "R7", "smallest base with ratio_int 4", min_base, 3);

    // R3 / R4: random settings
    for (int c = 0; c < 6; c++) begin
      logic [7:0] rn;
      logic [15:0] rf;
      rn = 8'(4 + ($urandom % 250));
      rf = 16'($urandom);
      run_cfg(rn, rf, 1500, 1'b1);
      check_stats(rf, 1500, "random");
    end

    // R2: gapped run reproduces the gap-free sequence
    do_reset();
    n_in = 8'd9; f_in = 16'h5B37;
    for (int i = 0; i < 40; i++) begin
      tick(1'b1);
      seq_b[i] = base; seq_k[i] = k;
    end
    do_reset();
    begin
      int mism, idle_bad;
      logic [7:0] hb;
      logic [2:0] hk;
      mism = 0; idle_bad = 0;
      for (int i = 0; i < 40; i++) begin
        int gap;
        gap = int'($urandom % 3);
        hb = base; hk = k;
        for (int g = 0; g < gap; g++) begin
          tick(1'b0);
          if (base != hb || k != hk) idle_bad++;
        end
        tick(1'b1);
        if (base != seq_b[i] || k != seq_k[i]) mism++;
      end
      check(idle_bad == 0, "R2", "output change while idle", idle_bad, 0);
      check(mism == 0, "R2", "events differing from gap-free run", mism, 0);
    end

    // R1: reset in the middle of a run
    do_reset();
    check(base == 8'd0 && k == 3'd0, "R1", "outputs after mid-run reset", {base, k}, 0);
    tick(1'b1);
    check(base == 8'd9 && k == 3'd2, "R1", "first event after mid-run reset", {base, k}, {8'd9, 3'd2});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule